// File: doc/BRIEF.md
# Input Delay Eye-Centering Calibrator

The calibrator sets a tap-programmable input delay on one serial data lane. The goal is for the capture clock edge to land in the middle of the open data eye. It works on the tap setting only; the analog delay line and the deserializer lie outside it. After a start request it steps the delay through every tap from 0 upward. For each tap it waits for the line to settle, then watches a fixed number of training-word comparisons reported by the deserializer. It keeps the longest unbroken run of passing taps.

At the end of the sweep it loads the tap halfway through that run and raises `done`, with the run length on `eyeWidth`. A run that is too narrow, or no passing tap at all, raises `error` instead and parks the delay at tap 0. The eye may be only a few taps wide, with each tap worth roughly 70 ps, so a window of four taps has to be found reliably. The block takes part only in the calibration phase; it does not track the eye during data taking.

Top module: `eye_center_cal`

## Requirements
- R1: After reset, `tapOut` is 0, `tapLoad` is 0, `done` is 0, `error` is 0 and `eyeWidth` is 0.
- R2: A cycle with `start` high, in any state, restarts calibration. In the next cycle `tapOut` is 0, `tapLoad` is 1, and `done` and `error` are 0.
- R3: `tapOut` changes only in a cycle where `tapLoad` is 1.
- R4: The sweep loads taps 0, 1, …, 2^TAP_W−1 in increasing order, one `tapLoad` pulse per tap. The first SETTLE_CYC cycles of each tap, starting with the cycle in which `tapLoad` is high, ignore `matchValid` and `matchOk`.
- R5: After settling, a tap passes only if all of the next WORDS beats with `matchValid` = 1 also carry `matchOk` = 1. Beats with `matchValid` = 0 are ignored, whatever `matchOk` shows.
- R6: The eye is the longest contiguous run of passing taps. When two runs have equal length, the run with the lower start tap is kept.
- R7: On success the final tap is floor((first + last) / 2) of the eye. It appears with a `tapLoad` pulse, and `done` rises in the following cycle with `eyeWidth` equal to the run length.
- R8: A run of at least MIN_EYE taps (default 2, so a 4-tap eye succeeds) gives `done`. Otherwise `error` rises one cycle after a `tapLoad` pulse that sets `tapOut` to 0, and `eyeWidth` holds the best run length (0 or 1).
- R9: `done` and `error` are never high together. Whichever of them is high stays high, with `tapOut` unchanged, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart calibration |
| matchValid | input | 1 | A training word has been compared this cycle |
| matchOk | input | 1 | The compared word matched the training pattern |
| tapOut | output | TAP_W | Delay tap setting for the delay line |
| tapLoad | output | 1 | Strobe: load `tapOut` into the delay line |
| done | output | 1 | Calibration succeeded; centre tap loaded |
| error | output | 1 | No usable eye was found; tap 0 loaded |
| eyeWidth | output | TAP_W+1 | Length in taps of the widest passing run |

## Verification
The assertions expect `start` to be a synchronous level sampled at each edge. They place no constraint on `matchValid` or `matchOk`, because the block is required to tolerate any values of these inputs during settling and on invalid beats. The bench derives `matchOk` from a per-tap eye mask indexed by the current `tapOut`. It forces mismatches only inside the settle window or on invalid beats, so that the eye the block should find is well defined. Near-exhaustive sweeps of 4-tap windows over every start position, together with tie, edge, narrow, empty and full masks, exercise the search and centring arithmetic.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic restart;     // clear everything, load tap 0
    logic settleTick;  // advance settle counter
    logic checkEn;     // accept training-word results
    logic evalTap;     // fold this tap's verdict into run tracking
    logic stepTap;     // load next tap
    logic finish;      // load centre (or 0) and capture width
    logic report;      // raise done or error
  } calStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_CHECK, ST_EVAL, ST_FINISH, ST_REPORT, ST_HOLD
  } calState_e;

endpackage

// File: rtl/eye_cal_ctrl.sv
module eye_cal_ctrl
  import eye_cal_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     settleDone,
  input  logic     wordsDone,
  input  logic     tapLast,
  output calStrb_t strb
);

  calState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    if (start) begin
      strb.restart = 1'b1;
      nextState    = ST_SETTLE;
    end else begin
      unique case (state)
        ST_IDLE: nextState = ST_IDLE;
        ST_SETTLE: begin
          strb.settleTick = 1'b1;
          if (settleDone) nextState = ST_CHECK;
        end
        ST_CHECK: begin
          strb.checkEn = 1'b1;
          if (wordsDone) nextState = ST_EVAL;
        end
        ST_EVAL: begin
          strb.evalTap = 1'b1;
          if (tapLast) nextState = ST_FINISH;
          else begin
            strb.stepTap = 1'b1;
            nextState    = ST_SETTLE;
          end
        end
        ST_FINISH: begin
          strb.finish = 1'b1;
          nextState   = ST_REPORT;
        end
        ST_REPORT: begin
          strb.report = 1'b1;
          nextState   = ST_HOLD;
        end
        ST_HOLD: nextState = ST_HOLD;
        default: nextState = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eye_cal_dp.sv
module eye_cal_dp
  import eye_cal_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int SETTLE_CYC = 8,
  parameter int WORDS      = 4,
  parameter int MIN_EYE    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrb_t         strb,
  input  logic             matchValid,
  input  logic             matchOk,
  output logic [TAP_W-1:0] tapOut,
  output logic             tapLoad,
  output logic             done,
  output logic             error,
  output logic [TAP_W:0]   eyeWidth,
  output logic             settleDone,
  output logic             wordsDone,
  output logic             tapLast
);

  localparam int LEN_W = TAP_W + 1;
  localparam int SC_W  = $clog2(SETTLE_CYC + 1);
  localparam int WC_W  = $clog2(WORDS + 1);

  logic [SC_W-1:0]  settleCnt;
  logic [WC_W-1:0]  wordCnt;
  logic             failSeen;
  logic [TAP_W-1:0] runStart, bestStart, bestEnd;
  logic [LEN_W-1:0] runLen, bestLen;

  logic [LEN_W-1:0] growLen;
  logic [TAP_W-1:0] growStart;
  logic [LEN_W-1:0] ctrSum;
  logic [TAP_W-1:0] ctrTap;
  logic             eyeOk;

  assign settleDone = (settleCnt == SC_W'(SETTLE_CYC - 1));
  assign wordsDone  = matchValid && (wordCnt == WC_W'(WORDS - 1));
  assign tapLast    = &tapOut;

  assign growLen   = runLen + LEN_W'(1);
  assign growStart = (runLen == '0) ? tapOut : runStart;
  assign ctrSum    = {1'b0, bestStart} + {1'b0, bestEnd};
  assign ctrTap    = ctrSum[TAP_W:1];
  assign eyeOk     = (bestLen >= LEN_W'(MIN_EYE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapOut    <= '0;
      tapLoad   <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      eyeWidth  <= '0;
      settleCnt <= '0;
      wordCnt   <= '0;
      failSeen  <= 1'b0;
      runStart  <= '0;
      runLen    <= '0;
      bestStart <= '0;
      bestEnd   <= '0;
      bestLen   <= '0;
    end else if (strb.restart) begin
      tapOut    <= '0;
      tapLoad   <= 1'b1;
      done      <= 1'b0;
      error     <= 1'b0;
      eyeWidth  <= '0;
      settleCnt <= '0;
      wordCnt   <= '0;
      failSeen  <= 1'b0;
      runStart  <= '0;
      runLen    <= '0;
      bestStart <= '0;
      bestEnd   <= '0;
      bestLen   <= '0;
    end else begin
      tapLoad <= 1'b0;
      if (strb.settleTick) settleCnt <= settleCnt + SC_W'(1);
      if (strb.checkEn && matchValid) begin
        wordCnt <= wordCnt + WC_W'(1);
        if (!matchOk) failSeen <= 1'b1;
      end
      if (strb.evalTap) begin
        if (failSeen) begin
          runLen <= '0;
        end else begin
          runLen   <= growLen;
          runStart <= growStart;
          if (growLen > bestLen) begin
            bestLen   <= growLen;
            bestStart <= growStart;
            bestEnd   <= tapOut;
          end
        end
      end
      if (strb.stepTap) begin
        tapOut    <= tapOut + TAP_W'(1);
        tapLoad   <= 1'b1;
        settleCnt <= '0;
        wordCnt   <= '0;
        failSeen  <= 1'b0;
      end
      if (strb.finish) begin
        tapOut   <= eyeOk ? ctrTap : '0;
        tapLoad  <= 1'b1;
        eyeWidth <= bestLen;
      end
      if (strb.report) begin
        done  <= eyeOk;
        error <= !eyeOk;
      end
    end
  end

endmodule

// File: rtl/eye_center_cal.sv
module eye_center_cal
  import eye_cal_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int SETTLE_CYC = 8,
  parameter int WORDS      = 4,
  parameter int MIN_EYE    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             matchValid,
  input  logic             matchOk,
  output logic [TAP_W-1:0] tapOut,
  output logic             tapLoad,
  output logic             done,
  output logic             error,
  output logic [TAP_W:0]   eyeWidth
);

  calStrb_t strb;
  logic     settleDone, wordsDone, tapLast;

  eye_cal_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .settleDone (settleDone),
    .wordsDone  (wordsDone),
    .tapLast    (tapLast),
    .strb       (strb)
  );

  eye_cal_dp #(
    .TAP_W      (TAP_W),
    .SETTLE_CYC (SETTLE_CYC),
    .WORDS      (WORDS),
    .MIN_EYE    (MIN_EYE)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .matchValid (matchValid),
    .matchOk    (matchOk),
    .tapOut     (tapOut),
    .tapLoad    (tapLoad),
    .done       (done),
    .error      (error),
    .eyeWidth   (eyeWidth),
    .settleDone (settleDone),
    .wordsDone  (wordsDone),
    .tapLast    (tapLast)
  );

endmodule

// File: rtl/eye_cal_chk.sv
module eye_cal_chk #(
  parameter int TAP_W   = 5,
  parameter int MIN_EYE = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [TAP_W-1:0] tapOut,
  input logic             tapLoad,
  input logic             done,
  input logic             error,
  input logic [TAP_W:0]   eyeWidth
);

  // R2
  restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (tapOut == '0) && tapLoad && !done && !error);

  // R3
  tap_only_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tapOut) |-> tapLoad);

  // R7
  done_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(tapLoad));

  // R7
  done_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (eyeWidth >= (TAP_W+1)'(MIN_EYE)));

  // R8
  error_tap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (tapOut == '0) && (eyeWidth < (TAP_W+1)'(MIN_EYE)));

  // R8
  error_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(tapLoad));

  // R9
  exclusive_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((done || error) && !start) |=> (done || error) && $stable(tapOut));

endmodule

bind eye_center_cal eye_cal_chk #(
  .TAP_W   (TAP_W),
  .MIN_EYE (MIN_EYE)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .tapOut   (tapOut),
  .tapLoad  (tapLoad),
  .done     (done),
  .error    (error),
  .eyeWidth (eyeWidth)
);

// File: tb/eye_center_cal_tb.sv
module eye_center_cal_tb_top;

  localparam int TAP_W      = 5;
  localparam int NTAPS      = 1 << TAP_W;
  localparam int SETTLE_CYC = 8;
  localparam int WORDS      = 4;
  localparam int MIN_EYE    = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             matchValid;
  logic             matchOk;
  logic [TAP_W-1:0] tapOut;
  logic             tapLoad;
  logic             done;
  logic             error;
  logic [TAP_W:0]   eyeWidth;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [NTAPS-1:0] eyeMask = '0;
  logic             altMode = 1'b0;
  logic             phase = 1'b0;
  int               sinceLoad = 100;
  logic             garbage;

  always #5 clk = ~clk;

  eye_center_cal #(
    .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .WORDS(WORDS), .MIN_EYE(MIN_EYE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .matchValid(matchValid),
    .matchOk(matchOk), .tapOut(tapOut), .tapLoad(tapLoad), .done(done),
    .error(error), .eyeWidth(eyeWidth)
  );

  // Lane model: mismatches while the delay settles, and on invalid beats
  always @(posedge clk) begin
    phase     <= ~phase;
    sinceLoad <= tapLoad ? 1 : ((sinceLoad < 100) ? sinceLoad + 1 : sinceLoad);
  end
  assign garbage    = tapLoad || (sinceLoad < SETTLE_CYC);
  assign matchValid = !altMode || phase;
  assign matchOk    = matchValid && eyeMask[tapOut] && !garbage;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NTAPS-1:0] win(input int s, input int w);
    logic [NTAPS-1:0] m = '0;
    for (int i = 0; i < NTAPS; i++) if (i >= s && i < s + w) m[i] = 1'b1;
    return m;
  endfunction

  task automatic runCal(input logic [NTAPS-1:0] m, input logic alt, input string tag);
    int bestLen = 0, bestS = 0, curLen = 0, curS = 0;
    int expTap, seq, prevTap, r3Bad, seqBad, waited;
    logic prevLoad, okExp;
    for (int i = 0; i < NTAPS; i++) begin
      if (m[i]) begin
        if (curLen == 0) curS = i;
        curLen++;
        if (curLen > bestLen) begin bestLen = curLen; bestS = curS; end
      end else curLen = 0;
    end
    okExp  = (bestLen >= MIN_EYE);
    expTap = okExp ? (bestS + (bestS + bestLen - 1)) / 2 : 0;

    @(negedge clk);
    eyeMask = m;
    altMode = alt;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {tag, " tap after start"}, int'(tapOut), 0);
    check("R2", {tag, " load after start"}, int'(tapLoad), 1);
    check("R2", {tag, " flags cleared"}, int'(done) + int'(error), 0);

    seq = 1; prevTap = 0; r3Bad = 0; seqBad = 0; waited = 0; prevLoad = 1'b1;
    while (!(done || error) && waited < 4000) begin
      prevLoad = tapLoad;
      @(negedge clk);
      waited++;
      if (tapOut != prevTap && !tapLoad) r3Bad++;
      prevTap = int'(tapOut);
      if (tapLoad) begin
        if (seq < NTAPS && int'(tapOut) != seq) seqBad++;
        seq++;
      end
    end
    check("R3", {tag, " tap moved without load"}, r3Bad, 0);
    check("R4", {tag, " sweep order errors"}, seqBad, 0);
    check("R4", {tag, " load pulses"}, seq, NTAPS + 1);
    check("R7", {tag, " load one cycle before result"}, int'(prevLoad), 1);
    check(okExp ? "R7" : "R8", {tag, " done"}, int'(done), int'(okExp));
    check(okExp ? "R7" : "R8", {tag, " error"}, int'(error), int'(!okExp));
    check(okExp ? "R6" : "R8", {tag, " final tap"}, int'(tapOut), expTap);
    check(okExp ? "R6" : "R8", {tag, " eye width"}, int'(eyeWidth), bestLen);
    repeat (4) @(negedge clk);
    check("R9", {tag, " result held"}, int'(done) * 2 + int'(error), okExp ? 2 : 1);
    check("R9", {tag, " tap held"}, int'(tapOut), expTap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset tap", int'(tapOut), 0);
    check("R1", "reset load", int'(tapLoad), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset error", int'(error), 0);
    check("R1", "reset width", int'(eyeWidth), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle tap after reset", int'(tapOut), 0);

    runCal(win(10, 4), 1'b0, "R8 four-tap eye");
    runCal(win(3, 8), 1'b0, "eight-tap eye");
    runCal(win(20, 2), 1'b0, "R8 two-tap eye");
    runCal(win(7, 1), 1'b0, "R8 one-tap eye");
    runCal('0, 1'b0, "R8 no eye");
    runCal('1, 1'b0, "full eye");
    runCal(win(2, 4) | win(20, 4), 1'b0, "R6 tie");
    runCal(win(1, 3) | win(15, 6), 1'b0, "R6 longer second");
    runCal(win(0, 4), 1'b0, "low edge");
    runCal(win(28, 4), 1'b0, "high edge");
    runCal(win(9, 5), 1'b1, "R5 sparse valid");
    runCal(win(4, 7) | win(14, 1), 1'b1, "R5 sparse valid two runs");

    // R4 and R5: every 4-tap window, alternating valid-beat pattern
    for (int s = 0; s <= NTAPS - 4; s++)
      runCal(win(s, 4), 1'(s % 2), "R4 window sweep");

    // R2: restart in the middle of a sweep
    @(negedge clk);
    eyeMask = win(5, 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (150) @(negedge clk);
    runCal(win(22, 6), 1'b0, "R2 mid-sweep restart");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule